// File: doc/BRIEF.md
# Cache-Aware Bus Command Selector

This block sits in the front end of a bus master. For each master transfer, and again for each later bus ownership that continues the same transfer, it picks the bus command code. It decides from five inputs: an 8-bit cache line size given in Dwords, a global cache enable, one enable for each cache command, the Dword start address and the remaining length in Dwords. It also returns a burst length cap for the ownership and a flag that shows a cache command was chosen.

The line size is only trusted when it is a power of two from 2 to 128. The block checks read commands against the position of the address inside its line. Write-and-invalidate needs a line-aligned start and at least one whole line to go, and its burst is trimmed to whole lines. The block keeps one registered bit across ownerships. It records whether the previous ownership of the transfer was planned to end on a line boundary. A continuing write may only go back to write-and-invalidate when that bit is set and the new address is aligned.

The caller pulses `start_i` for one cycle with the inputs valid. One clock later the command, cap and cache flag are registered, and `done_o` pulses for that cycle. The outputs then hold until the next start.

Top module: `cache_cmd_sel`

## Requirements
- R1: A line size is valid only when it is 2, 4, 8, 16, 32, 64 or 128. Any other value, including 0, 1 and 255, gives only plain commands: read 4'b0110 or write 4'b0111, with `cache_o` low.
- R2: When `cache_en_i` is low, no cache command is chosen, whatever the other inputs are.
- R3: A command whose own enable (`en_rline_i`, `en_rmult_i`, `en_winv_i`) is low is never issued.
- R4: On a read with cache usable, if the multiple-read enable is set and `len_i` is greater than the line size, the command is 4'b1100.
- R5: Otherwise a read uses 4'b1110 if the line-read enable is set and `len_i` is at least the number of Dwords from `addr_i` to the end of its line. In all remaining cases a read uses 4'b0110. For every read the cap equals `len_i`.
- R6: A write uses 4'b1111 only when all of these hold: cache is usable, its enable is set, the low address bits below log2(line size) are zero, and `len_i` is at least one line. Its cap is then `len_i` rounded down to whole lines.
- R7: Any other write uses 4'b0111 with cap equal to `len_i`.
- R8: When `first_i` is low (a later ownership of the same transfer), write-and-invalidate also needs this: the previous start must have had `addr + cap` on a line boundary. When `first_i` is high, that history is ignored. After reset the history bit is clear.
- R9: Outputs change only at the clock edge that follows a start, `done_o` is high for exactly that one cycle, and outputs hold while no start is given.
- R10: After reset `cmd_o`, `cap_o`, `cache_o` and `done_o` are all zero.
- R11: `cache_o` is high exactly when the registered command is 4'b1100, 4'b1110 or 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe: evaluate the inputs |
| first_i | input | 1 | High for the first ownership of a new transfer |
| write_i | input | 1 | Transfer direction, high for write |
| addr_i | input | ADDR_W (32) | Dword start address for this ownership |
| len_i | input | LEN_W (16) | Remaining length in Dwords |
| line_size_i | input | 8 | Cache line size in Dwords |
| cache_en_i | input | 1 | Global cache command enable |
| en_rline_i | input | 1 | Enable for read-line command |
| en_rmult_i | input | 1 | Enable for read-multiple command |
| en_winv_i | input | 1 | Enable for write-and-invalidate command |
| cmd_o | output | 4 | Selected bus command code |
| cap_o | output | LEN_W (16) | Burst length cap for this ownership |
| cache_o | output | 1 | A cache command was selected |
| done_o | output | 1 | One-cycle pulse: outputs are valid |

## Verification
The hardest case to reach from the ports is a continuing write that arrives at an aligned address with a whole line left, yet must still fall back to plain write. This happens because the earlier ownership's planned end was off a line boundary. The stimulus builds this with chains of starts. First comes an unaligned first ownership, then an aligned continuation. It also runs a write-and-invalidate ownership that leaves a partial-line remainder, followed by aligned and unaligned continuations. The model carries the history bit across these chains on its own and compares the results.

// File: rtl/cmdsel_pkg.sv
package cmdsel_pkg;
  localparam int CLS_W = 8;

  typedef enum logic [3:0] {
    CMD_MRD = 4'b0110,
    CMD_MWR = 4'b0111,
    CMD_MRM = 4'b1100,
    CMD_MRL = 4'b1110,
    CMD_MWI = 4'b1111
  } bus_cmd_e;

  function automatic logic is_cache_cmd(input logic [3:0] c);
    return (c == CMD_MRM) || (c == CMD_MRL) || (c == CMD_MWI);
  endfunction
endpackage

// File: rtl/cls_decode.sv
module cls_decode #(
  parameter int CLS_W = 8
) (
  input  logic [CLS_W-1:0] cls_i,
  output logic             valid_o,
  output logic [CLS_W-1:0] mask_o
);
  logic [CLS_W-1:0] hit;

  // One-hot match for each legal power of two, excluding 1.
  assign hit[0] = 1'b0;
  for (genvar k = 1; k < CLS_W; k++) begin : g_pow
    assign hit[k] = (cls_i == CLS_W'(1 << k));
  end

  always_comb begin
    valid_o = |hit;
    mask_o  = '0;
    if (valid_o) begin
      mask_o = cls_i - CLS_W'(1);
    end
  end
endmodule

// File: rtl/cmd_pick.sv
module cmd_pick
  import cmdsel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int CLS_W  = 8
) (
  input  logic              write_i,
  input  logic              first_i,
  input  logic              hist_ok_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [CLS_W-1:0]  cls_i,
  input  logic              usable_i,
  input  logic [CLS_W-1:0]  mask_i,
  input  logic              en_rline_i,
  input  logic              en_rmult_i,
  input  logic              en_winv_i,
  output logic [3:0]        cmd_o,
  output logic [LEN_W-1:0]  cap_o,
  output logic              cache_o,
  output logic              end_line_o
);
  localparam int PAD_W = LEN_W - CLS_W;

  logic [LEN_W-1:0] line_len;
  logic [LEN_W-1:0] mask_len;
  logic [CLS_W-1:0] offset;
  logic [LEN_W-1:0] to_end;
  logic [LEN_W-1:0] whole_lines;
  logic             addr_aligned;
  logic             winv_ok;
  logic [CLS_W-1:0] end_low;

  always_comb begin
    line_len     = {{PAD_W{1'b0}}, cls_i};
    mask_len     = {{PAD_W{1'b0}}, mask_i};
    offset       = addr_i[CLS_W-1:0] & mask_i;
    to_end       = line_len - {{PAD_W{1'b0}}, offset};
    whole_lines  = len_i & ~mask_len;
    addr_aligned = usable_i && (offset == '0);
    winv_ok      = usable_i && en_winv_i && addr_aligned &&
                   (len_i >= line_len) && (first_i || hist_ok_i);
  end

  always_comb begin
    cmd_o = CMD_MRD;
    cap_o = len_i;
    if (write_i) begin
      if (winv_ok) begin
        cmd_o = CMD_MWI;
        cap_o = whole_lines;
      end else begin
        cmd_o = CMD_MWR;
      end
    end else if (usable_i && en_rmult_i && (len_i > line_len)) begin
      cmd_o = CMD_MRM;
    end else if (usable_i && en_rline_i && (len_i >= to_end)) begin
      cmd_o = CMD_MRL;
    end
    cache_o = (cmd_o != CMD_MRD) && (cmd_o != CMD_MWR);
  end

  // Planned end of this ownership, checked against a line boundary.
  always_comb begin
    end_low    = addr_i[CLS_W-1:0] + cap_o[CLS_W-1:0];
    end_line_o = usable_i && ((end_low & mask_i) == '0);
  end
endmodule

// File: rtl/own_tracker.sv
module own_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic end_line_i,
  output logic hist_ok_o
);
  logic hist_d;
  logic hist_q;

  always_comb begin
    hist_d = hist_q;
    if (start_i) begin
      hist_d = end_line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
    end
  end

  assign hist_ok_o = hist_q;

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(hist_q)); // R8
  AST_HIST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (hist_q == $past(end_line_i))); // R8
endmodule

// File: rtl/cache_cmd_sel.sv
module cache_cmd_sel
  import cmdsel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              first_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [7:0]        line_size_i,
  input  logic              cache_en_i,
  input  logic              en_rline_i,
  input  logic              en_rmult_i,
  input  logic              en_winv_i,
  output logic [3:0]        cmd_o,
  output logic [LEN_W-1:0]  cap_o,
  output logic              cache_o,
  output logic              done_o
);
  localparam int SZ_W = CLS_W;

  logic             size_ok;
  logic [SZ_W-1:0]  size_mask;
  logic             usable;
  logic             hist_ok;
  logic [3:0]       pick_cmd;
  logic [LEN_W-1:0] pick_cap;
  logic             pick_cache;
  logic             pick_end_line;

  logic [3:0]       cmd_d,   cmd_q;
  logic [LEN_W-1:0] cap_d,   cap_q;
  logic             cache_d, cache_q;
  logic             done_d,  done_q;

  cls_decode #(.CLS_W(SZ_W)) u_dec (
    .cls_i   (line_size_i),
    .valid_o (size_ok),
    .mask_o  (size_mask)
  );

  assign usable = cache_en_i && size_ok;

  cmd_pick #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CLS_W(SZ_W)) u_pick (
    .write_i    (write_i),
    .first_i    (first_i),
    .hist_ok_i  (hist_ok),
    .addr_i     (addr_i),
    .len_i      (len_i),
    .cls_i      (line_size_i),
    .usable_i   (usable),
    .mask_i     (size_mask),
    .en_rline_i (en_rline_i),
    .en_rmult_i (en_rmult_i),
    .en_winv_i  (en_winv_i),
    .cmd_o      (pick_cmd),
    .cap_o      (pick_cap),
    .cache_o    (pick_cache),
    .end_line_o (pick_end_line)
  );

  own_tracker u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .end_line_i (pick_end_line),
    .hist_ok_o  (hist_ok)
  );

  always_comb begin
    cmd_d   = cmd_q;
    cap_d   = cap_q;
    cache_d = cache_q;
    done_d  = 1'b0;
    if (start_i) begin
      cmd_d   = pick_cmd;
      cap_d   = pick_cap;
      cache_d = pick_cache;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      cap_q   <= '0;
      cache_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      cap_q   <= cap_d;
      cache_q <= cache_d;
      done_q  <= done_d;
    end
  end

  assign cmd_o   = cmd_q;
  assign cap_o   = cap_q;
  assign cache_o = cache_q;
  assign done_o  = done_q;

  AST_BAD_SIZE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !size_ok) |=> !cache_o); // R1
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cache_en_i) |=> !cache_o); // R2
  AST_WINV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !en_winv_i) |=> (cmd_o != CMD_MWI)); // R3
  AST_RLINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !en_rline_i) |=> (cmd_o != CMD_MRL)); // R3
  AST_WINV_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && write_i) |=> ((cmd_o != CMD_MWI) ||
      ((cap_o[SZ_W-1:0] & $past(size_mask)) == '0 && cap_o != '0))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o); // R9
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (!done_o && $stable(cmd_o) && $stable(cap_o))); // R9
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cache_o == is_cache_cmd(cmd_o))); // R11
endmodule

// File: tb/cache_cmd_sel_test.sv
module cache_cmd_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, first_i = 1'b0, write_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [15:0] len_i = '0;
  logic [7:0]  line_size_i = '0;
  logic        cache_en_i = 1'b0, en_rline_i = 1'b0, en_rmult_i = 1'b0, en_winv_i = 1'b0;
  logic [3:0]  cmd_o;
  logic [15:0] cap_o;
  logic        cache_o, done_o;

  int total = 0;
  int bad = 0;
  bit hist_m = 0;

  always #10 clk = ~clk;

  cache_cmd_sel uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_i(first_i),
    .write_i(write_i), .addr_i(addr_i), .len_i(len_i),
    .line_size_i(line_size_i), .cache_en_i(cache_en_i),
    .en_rline_i(en_rline_i), .en_rmult_i(en_rmult_i), .en_winv_i(en_winv_i),
    .cmd_o(cmd_o), .cap_o(cap_o), .cache_o(cache_o), .done_o(done_o)
  );

  initial begin
    #3_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic op(string req, bit wr, bit first, int addr, int len, int ls,
                    bit gen, bit erl, bit erm, bit ewi);
    int exp_cmd, exp_cap, end_addr;
    bit valid, usable, aligned;
    valid  = (ls == 2 || ls == 4 || ls == 8 || ls == 16 || ls == 32 || ls == 64 || ls == 128);
    usable = gen && valid;
    aligned = usable && (addr % ls == 0);
    exp_cap = len;
    if (wr) begin
      if (usable && ewi && aligned && len >= ls && (first || hist_m)) begin
        exp_cmd = 4'b1111; exp_cap = (len / ls) * ls;
      end else exp_cmd = 4'b0111;
    end else if (usable && erm && len > ls) exp_cmd = 4'b1100;
    else if (usable && erl && len >= ls - (addr % ls)) exp_cmd = 4'b1110;
    else exp_cmd = 4'b0110;
    end_addr = addr + exp_cap;
    @(negedge clk);
    start_i = 1'b1; first_i = first; write_i = wr; addr_i = addr; len_i = 16'(len);
    line_size_i = 8'(ls); cache_en_i = gen; en_rline_i = erl; en_rmult_i = erm; en_winv_i = ewi;
    @(negedge clk);
    start_i = 1'b0;
    hist_m = usable && (end_addr % ls == 0);
    check(req, "done", int'(done_o), 1);
    check(req, "cmd", int'(cmd_o), exp_cmd);
    check(req, "cap", int'(cap_o), exp_cap);
    check("R11", "cache", int'(cache_o),
          (exp_cmd == 4'b1100 || exp_cmd == 4'b1110 || exp_cmd == 4'b1111) ? 1 : 0);
    // Change inputs without a start: outputs must hold (R9).
    addr_i = addr + 1; len_i = 16'(len + 5); write_i = ~wr;
    @(negedge clk);
    check("R9", "done low", int'(done_o), 0);
    check("R9", "cmd held", int'(cmd_o), exp_cmd);
    check("R9", "cap held", int'(cap_o), exp_cap);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R10", "cmd", int'(cmd_o), 0);
    check("R10", "cap", int'(cap_o), 0);
    check("R10", "cache", int'(cache_o), 0);
    check("R10", "done", int'(done_o), 0);
    rst_n = 1'b1;
    // Reads
    op("R4", 0, 1, 0, 20, 8, 1, 1, 1, 1);
    op("R5", 0, 1, 5, 3, 8, 1, 1, 1, 1);
    op("R5", 0, 1, 5, 2, 8, 1, 1, 1, 1);
    op("R3", 0, 1, 0, 20, 8, 1, 1, 0, 1);
    op("R3", 0, 1, 0, 20, 8, 1, 0, 0, 1);
    op("R4", 0, 1, 64, 129, 128, 1, 1, 1, 1);
    // Line size validity and global enable
    op("R1", 0, 1, 0, 40, 12, 1, 1, 1, 1);
    op("R1", 0, 1, 0, 40, 0, 1, 1, 1, 1);
    op("R1", 1, 1, 0, 40, 1, 1, 1, 1, 1);
    op("R1", 1, 1, 0, 40, 255, 1, 1, 1, 1);
    op("R2", 0, 1, 0, 40, 8, 0, 1, 1, 1);
    op("R2", 1, 1, 0, 40, 8, 0, 1, 1, 1);
    // Writes on first ownership
    op("R6", 1, 1, 16, 20, 8, 1, 1, 1, 1);
    op("R8", 1, 0, 32, 4, 8, 1, 1, 1, 1);
    op("R7", 1, 1, 3, 40, 8, 1, 1, 1, 1);
    op("R8", 1, 0, 8, 35, 8, 1, 1, 1, 1);
    op("R6", 1, 1, 0, 32, 8, 1, 1, 1, 1);
    op("R8", 1, 0, 40, 16, 8, 1, 1, 1, 1);
    op("R6", 1, 1, 0, 28, 8, 1, 1, 1, 1);
    op("R8", 1, 0, 26, 10, 8, 1, 1, 1, 1);
    op("R8", 1, 1, 8, 16, 8, 1, 1, 1, 1);
    op("R3", 1, 1, 0, 32, 8, 1, 1, 1, 0);
    op("R7", 1, 1, 0, 7, 8, 1, 1, 1, 1);
    op("R6", 1, 1, 128, 300, 128, 1, 1, 1, 1);
    op("R6", 1, 1, 2, 5, 2, 1, 1, 1, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule